// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit applies one of a small set of saturating integer operations to 64-bit operands and presents the result from an output register one clock later. The operations are a 64-bit signed add that clamps instead of wrapping, signed and unsigned narrowing of a 64-bit value to 8, 16 or 32 bits, a clip to a symmetric power-of-two range, and a convergent round of a value whose two low bits are fraction bits. A 3-bit opcode, two operands and a 6-bit parameter are sampled on every rising clock edge. The parameter carries the narrowing width or the clip exponent.

A single sticky overflow flag is shared by the add and both narrowing operations. It is set whenever any of them has to replace the true value with a bound. It stays set until the clear input is raised. The unit has no handshake. A new operation can be issued on every cycle.

Top module: `sat_alu`

## Requirements
- R1: While reset (active low) is asserted, `res` is 0 and `ovf` is 0.
- R2: Opcode 0 with operands whose bit 63 differs returns the wrapped 64-bit sum a+b and does not set `ovf`.
- R3: Opcode 0 with operands of equal sign returns the wrapped sum if its bit 63 matches a's. Otherwise it returns 0x7FFF_FFFF_FFFF_FFFF when the sum's bit 63 is 1, returns 0x8000_0000_0000_0000 when it is 0, and sets `ovf`.
- R4: Opcode 1 narrows a to signed N bits, with N = 8 for prm[1:0]=0, 16 for 1, and 32 for 2 or 3. A value that lies in [-(2^(N-1)), 2^(N-1)-1] is kept. Any other value becomes the nearer bound and sets `ovf`.
- R5: Opcode 2 narrows a to unsigned N bits, with N chosen as in R4. A value whose bits at N and above are all 0 is kept. A value with bit 63 set becomes 0, any other value becomes 2^N-1, and either case sets `ovf`.
- R6: Opcode 3 clips signed a to [-(2^U), 2^U-1], where U = prm[5:0] and values above 62 are treated as 62. It never changes `ovf`.
- R7: Opcode 4 returns a+1 (wrapping) when a[1:0] is 3 and returns a otherwise. It never changes `ovf`.
- R8: Opcodes 5, 6 and 7 return a unchanged and never change `ovf`.
- R9: `ovf` stays set until `clr_ovf` is sampled high. `clr_ovf` clears it on that edge even if a saturating operation is sampled on the same edge.
- R10: The result of an operation sampled on a rising edge appears on `res` immediately after that edge and is held until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| op | input | 3 | Operation select |
| a | input | 64 | First operand |
| b | input | 64 | Second operand (add only) |
| prm | input | 6 | Width select in bits 1:0, or clip exponent |
| res | output | 64 | Registered result |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The add is tried with operands of mixed sign, which must always wrap silently. It is also tried with same-sign operands near both 64-bit extremes, which separates a correct clamp from a wrapped sum and shows which bound each direction takes. The narrowing operations get values just inside and just outside each bound at every width, plus negative inputs to the unsigned form. These tell a sign-extension check from a zero-extension check and show whether the width select is decoded correctly. Clip is tried across exponents including the capped top one. Random mixes of all opcodes, with occasional clears, check that only the saturating operations feed the sticky flag and that a clear wins over a same-edge overflow.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W = 64,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_ovf,
  input  logic [2:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [PW-1:0] prm,
  output logic [W-1:0]  res,
  output logic          ovf
);
  localparam int UMAX = W - 2;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sum, add_v, ssat_v, usat_v, clip_v, rnd_v, nxt;
  logic         add_o, ssat_o, usat_o, ev;
  int           n, u;
  logic [W-1:0] smax, umax, chi, sh;

  assign sum   = a + b;
  assign add_o = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign add_v = add_o ? (sum[W-1] ? POS_MAX : NEG_MIN) : sum;

  always_comb begin
    case (prm[1:0])
      2'd0:    n = 8;
      2'd1:    n = 16;
      default: n = 32;
    endcase
    u = (int'(prm) > UMAX) ? UMAX : int'(prm);
  end

  assign smax   = (W'(1) << (n - 1)) - W'(1);
  assign umax   = (W'(1) << n) - W'(1);
  assign sh     = W'($signed(a) >>> (n - 1));
  assign ssat_o = !((sh == '0) || (sh == '1));
  assign ssat_v = ssat_o ? (a[W-1] ? ~smax : smax) : a;
  assign usat_o = (a >> n) != '0;
  assign usat_v = usat_o ? (a[W-1] ? '0 : umax) : a;

  assign chi    = (W'(1) << u) - W'(1);
  assign clip_v = ($signed(a) > $signed(chi)) ? chi :
                  ($signed(a) < $signed(~chi)) ? ~chi : a;
  assign rnd_v  = (a[1:0] == 2'b11) ? a + W'(1) : a;

  always_comb begin
    nxt = a;
    ev  = 1'b0;
    case (op)
      3'd0: begin nxt = add_v;  ev = add_o;  end
      3'd1: begin nxt = ssat_v; ev = ssat_o; end
      3'd2: begin nxt = usat_v; ev = usat_o; end
      3'd3: nxt = clip_v;
      3'd4: nxt = rnd_v;
      default: nxt = a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0;
      ovf <= 1'b0;
    end else begin
      res <= nxt;
      ovf <= clr_ovf ? 1'b0 : (ovf | ev);
    end
  end
endmodule

module sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_ovf,
  input logic [2:0]  op,
  input logic [63:0] a,
  input logic [63:0] b,
  input logic [5:0]  prm,
  input logic [63:0] res,
  input logic        ovf
);
  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);
  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf |=> !ovf);
  // R2
  add_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 && a[63] != b[63]) |=> (res == $past(a) + $past(b)));
  // R4
  ssat8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && prm[1:0] == 2'd0) |=> ((&res[63:7]) || !(|res[63:7])));
  // R5
  usat8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && prm[1:0] == 2'd0) |=> (res[63:8] == 56'd0));
  // R6
  clip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && !ovf && !clr_ovf) |=> !ovf);
  // R8
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 3'd5) |=> (res == $past(a)));
endmodule

bind sat_alu sat_alu_chk chk_i (.*);

// File: tb/sat_alu_tb.sv
module sat_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        clr_ovf = 0;
  logic [2:0]  op = 0;
  logic [63:0] a = 0, b = 0;
  logic [5:0]  prm = 0;
  logic [63:0] res;
  logic        ovf;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_alu dut_i (.clk(clk), .rst_n(rst_n), .clr_ovf(clr_ovf), .op(op),
                 .a(a), .b(b), .prm(prm), .res(res), .ovf(ovf));

  function automatic int width_of(logic [5:0] p);
    return (p[1:0] == 0) ? 8 : (p[1:0] == 1) ? 16 : 32;
  endfunction

  function automatic logic [64:0] model(logic [2:0] o, logic [63:0] x,
                                        logic [63:0] y, logic [5:0] p);
    longint sx, sy, s, hi, lo;
    int n, u;
    sx = x; sy = y;
    n = width_of(p);
    case (o)
      0: begin
        s = sx + sy;
        if (sx >= 0 && sy >= 0 && s < 0) return {1'b1, 64'h7FFFFFFFFFFFFFFF};
        if (sx < 0 && sy < 0 && s >= 0)  return {1'b1, 64'h8000000000000000};
        return {1'b0, s};
      end
      1: begin
        hi = (longint'(1) <<< (n-1)) - 1; lo = -hi - 1;
        if (sx > hi) return {1'b1, hi};
        if (sx < lo) return {1'b1, lo};
        return {1'b0, x};
      end
      2: begin
        hi = (longint'(1) <<< n) - 1;
        if (sx < 0)  return {1'b1, 64'd0};
        if (sx > hi) return {1'b1, hi};
        return {1'b0, x};
      end
      3: begin
        u = (p > 62) ? 62 : int'(p);
        hi = (longint'(1) <<< u) - 1; lo = -hi - 1;
        if (sx > hi) return {1'b0, hi};
        if (sx < lo) return {1'b0, lo};
        return {1'b0, x};
      end
      4: return {1'b0, (x % 4 == 3) ? x + 64'd1 : x};
      default: return {1'b0, x};
    endcase
  endfunction

  task automatic run(input logic [2:0] o, input logic [63:0] x,
                     input logic [63:0] y, input logic [5:0] p,
                     input logic c, input string tag);
    logic [64:0] e;
    @(negedge clk);
    op = o; a = x; b = y; prm = p; clr_ovf = c;
    e = model(o, x, y, p);
    exp_ovf = c ? 1'b0 : (exp_ovf | e[64]);
    @(posedge clk); #1;
    checks++;
    if (res !== e[63:0]) begin
      errors++;
      $display("FAIL %s res op=%0d actual=%h expected=%h", tag, o, res, e[63:0]);
    end
    checks++;
    if (ovf !== exp_ovf) begin
      errors++;
      $display("FAIL %s ovf op=%0d actual=%b expected=%b", tag, o, ovf, exp_ovf);
    end
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return {$urandom, $urandom};
      1: return 64'h7FFFFFFFFFFFFFFF - 64'($urandom % 16);
      2: return 64'h8000000000000000 + 64'($urandom % 16);
      3: return 64'($signed(($urandom % 801) - 400));
      4: return 64'($signed(32'h7FFFFFF0 + ($urandom % 32)));
      default: return {$urandom, $urandom} >>> ($urandom % 64);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (res !== 64'd0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", res, ovf);
    end
    @(negedge clk); rst_n = 1;

    run(0, 64'h7FFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 0, 0, "R2 mixed");
    run(0, 64'h8000000000000000, 64'h0000000000000005, 0, 0, "R2 mixed");
    run(0, 64'h7FFFFFFFFFFFFFFF, 64'd1, 0, 0, "R3 pos clamp");
    run(0, 64'd0, 64'd0, 0, 1, "R9 clear");
    run(0, 64'h8000000000000000, 64'h8000000000000000, 0, 0, "R3 neg clamp");
    run(7, 64'h1234, 0, 0, 0, "R9 hold");
    run(1, 64'd200, 0, 0, 1, "R4 s8 hi");
    run(1, 64'd127, 0, 0, 1, "R4 s8 keep");
    run(1, -64'd128, 0, 0, 1, "R4 s8 keep lo");
    run(1, -64'd129, 0, 0, 0, "R4 s8 lo");
    run(1, 64'd40000, 0, 1, 1, "R4 s16 hi");
    run(1, 64'h80000000, 0, 3, 1, "R4 s32 code3");
    run(2, -64'd5, 0, 0, 1, "R5 u8 neg");
    run(2, 64'd255, 0, 0, 1, "R5 u8 keep");
    run(2, 64'd256, 0, 0, 1, "R5 u8 hi");
    run(2, 64'h1_0000_0000, 0, 2, 1, "R5 u32 hi");
    run(3, 64'd100, 0, 3, 1, "R6 clip hi");
    run(3, -64'd100, 0, 3, 0, "R6 clip lo");
    run(3, 64'h7FFFFFFFFFFFFFFF, 0, 63, 0, "R6 clip cap");
    run(4, 64'd7, 0, 0, 0, "R7 round up");
    run(4, 64'd6, 0, 0, 0, "R7 round keep");
    run(4, 64'hFFFFFFFFFFFFFFFF, 0, 0, 0, "R7 round wrap");
    run(5, 64'hDEADBEEF, 0, 0, 0, "R8 pass5");
    run(6, 64'h8000000000000000, 64'd9, 0, 0, "R8 pass6");
    run(0, 64'h7FFFFFFFFFFFFFFF, 64'd3, 0, 1, "R9 clear wins");
    run(2, 64'd17, 0, 0, 0, "R10 latency");
    run(1, 64'd300, 0, 0, 0, "R10 back to back");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      o = 3'($urandom % 8);
      if ($urandom % 4 != 0) o = 3'($urandom % 4);
      run(o, pick(), pick(), 6'($urandom), ($urandom % 16) == 0, "R3 R4 R5 R6 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule